// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a single PCI function and serves configuration reads and writes against it. Each request carries a 16-bit address, an access size of 1, 2 or 4 bytes, 32-bit write data and a write flag. The address packs a device number, a function number and a register offset. Requests meant for a different device or function are ignored. The block answers every request one clock later with registered read data and an error flag.

Most of the header is read-only and comes out of reset holding values fixed by parameters: identifiers, class code, header type and interrupt pin. Software may write three kinds of register. The 16-bit command register takes its write data directly. The expansion ROM base register stores what is written to it, except for one probe value. Six base address registers (BARs) support the usual sizing probe: writing all ones makes a BAR read back a mask built from its size parameter, with its type bits kept. An ordinary write stores a new base and leaves the protected low bits alone. When a BAR gets its first nonzero base, the block gives a one-cycle "map add" pulse for that BAR. Every later nonzero base gives a "map change" pulse, so a downstream address decoder can install or move the window.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: A request matches only when address bits 15:11 equal the device parameter and bits 10:8 equal the function parameter. A read that does not match answers with data zero and no error. A write that does not match answers with the error flag set and changes no register.
- R2: A request sampled on a rising edge is answered on the following edge: rsp_valid is high for exactly one cycle, and no response appears without a request. A matched read of size 1, 2 or 4 returns, little-endian, the bytes starting at offset bits 7:0, with unused upper data bytes at zero.
- R3: A matched access whose size is not 1, 2 or 4 raises the error flag, returns data zero and changes no register.
- R4: After reset, the header holds these values: vendor ID at byte 0x00 (16 bits), device ID at 0x02 (16 bits), command at 0x04 (zero), status at 0x06 (zero), revision at 0x08, class code at 0x09..0x0B, header type at 0x0E, and interrupt pin at 0x3D. The six BARs sit at 0x10 + 4·n. Each BAR resets to its type bits (bit 0 set means I/O), and the ROM base at 0x30 resets to zero. All other bytes are zero, and no response or map pulse is active.
- R5: Header bytes at offsets 0x40 and above read as zero, including the upper bytes of a multi-byte read that runs past the end of the header.
- R6: A 4-byte write of 0xFFFFFFFF to a BAR with nonzero size S makes it read ~(S-1) ORed with its protected low bits. This sizing probe raises no map pulse.
- R7: Any other 4-byte BAR write stores the write data, except that the protected low bits keep their current value. The protected bits are the low 2 bits when bit 0 is set (I/O BAR) and the low 4 bits otherwise (memory BAR).
- R8: A BAR whose size parameter is zero always reads zero. Writes to it are accepted without error and raise no map pulse.
- R9: A 4-byte write of 0xFFFFFFFE to the ROM base at 0x30 makes it read 0xFFFFFFFF. Any other 4-byte write there is stored unchanged.
- R10: A 2-byte write at offset 0x04 loads the command register with write data bits 15:0.
- R11: Any other matched write of a legal size raises the error flag and leaves the header unchanged. This covers read-only bytes, unaligned BAR or ROM writes, and writes at 0x04 of a size other than 2.
- R12: A non-probe write with nonzero data to a live BAR makes exactly one pulse, on the response cycle. If the BAR has never had a nonzero base, the pulse is map_add for that BAR; otherwise it is map_change. A write of zero data makes no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Device [15:11], function [10:8], register offset [7:0] |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, little-endian from the offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Error flag for the answered request |
| map_add | output | NUM_BAR | Per-BAR pulse: first nonzero base assigned |
| map_change | output | NUM_BAR | Per-BAR pulse: base reassigned |

## Verification
A table of reads taken just after reset covers every size at aligned and odd offsets, plus a read that runs past 0x3F. These reads show whether the byte order, the size masking and the end-of-header zero fill are right. Next, BAR probes and ordinary writes go to an I/O BAR, a plain memory BAR, a memory BAR with extra type bits and a BAR of size zero. These show whether the protection width (two bits or four) and the size mask are correct. A run of zero, first-nonzero and repeated nonzero writes shows map_add apart from map_change. Last, mismatched device or function numbers, illegal sizes and writes to read-only or misaligned offsets confirm that rejected requests leave the readable state unchanged.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int HDR_BYTES = 64;
  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_BAR0 = 8'h10;
  localparam logic [7:0] OFF_ROM  = 8'h30;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // low bits that software cannot change: 2 for I/O, 4 for memory
  function automatic logic [31:0] keep_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  function automatic logic [31:0] bar_sized(input logic [31:0] sz, input logic [31:0] cur);
    return ~(sz - 32'd1) | (cur & keep_mask(cur[0]));
  endfunction

  function automatic logic [31:0] bar_merge(input logic [31:0] wd, input logic [31:0] cur);
    logic [31:0] m;
    m = keep_mask(cur[0]);
    return (wd & ~m) | (cur & m);
  endfunction

  function automatic logic [31:0] rom_next(input logic [31:0] wd);
    return (wd == ROM_PROBE) ? ALL_ONES : wd;
  endfunction
endpackage

// File: rtl/cfgh_decode.sv
module cfgh_decode
  import cfgh_pkg::*;
#(
  parameter int         NUM_BAR  = 6,
  parameter logic [4:0] DEV_NUM  = 5'd3,
  parameter logic [2:0] FUNC_NUM = 3'd1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output logic              hit,
  output logic              rd_en,
  output logic [7:0]        offset,
  output logic              wr_cmd,
  output logic              wr_rom,
  output logic [NUM_BAR-1:0] wr_bar,
  output logic              err_d
);
  logic size_ok;
  logic wr_ok;
  logic any_target;

  assign hit     = (req_addr[15:11] == DEV_NUM) && (req_addr[10:8] == FUNC_NUM);
  assign offset  = req_addr[7:0];
  assign size_ok = size_legal(req_size);
  assign wr_ok   = req_valid && req_write && hit && size_ok;
  assign rd_en   = req_valid && !req_write && hit && size_ok;

  assign wr_cmd = wr_ok && (offset == OFF_CMD) && (req_size == 3'd2);
  assign wr_rom = wr_ok && (offset == OFF_ROM) && (req_size == 3'd4);

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar_sel
    assign wr_bar[i] = wr_ok && (offset == (OFF_BAR0 + 8'(4 * i))) && (req_size == 3'd4);
  end

  assign any_target = wr_cmd || wr_rom || (|wr_bar);

  always_comb begin
    err_d = 1'b0;
    if (req_valid) begin
      if (req_write) err_d = !any_target;
      else           err_d = hit && !size_ok;
    end
  end
endmodule

// File: rtl/cfgh_bar.sv
module cfgh_bar
  import cfgh_pkg::*;
#(
  parameter logic [31:0] BAR_SZ   = 32'h100,
  parameter logic [3:0]  LOW_INIT = 4'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q,
  output logic        add_pulse,
  output logic        chg_pulse
);
  localparam logic LIVE = (BAR_SZ != 32'd0);
  localparam logic [3:0] LOW_KEEP = LOW_INIT & (LOW_INIT[0] ? 4'h3 : 4'hF);
  localparam logic [31:0] RST_VAL = LIVE ? {28'd0, LOW_KEEP} : 32'd0;

  logic assigned;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q     <= RST_VAL;
      assigned  <= 1'b0;
      add_pulse <= 1'b0;
      chg_pulse <= 1'b0;
    end else begin
      add_pulse <= 1'b0;
      chg_pulse <= 1'b0;
      if (we && LIVE) begin
        if (wdata == ALL_ONES) begin
          bar_q <= bar_sized(BAR_SZ, bar_q);
        end else begin
          bar_q <= bar_merge(wdata, bar_q);
          if (wdata != 32'd0) begin
            if (!assigned) begin
              add_pulse <= 1'b1;
              assigned  <= 1'b1;
            end else begin
              chg_pulse <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfgh_rdport.sv
module cfgh_rdport
  import cfgh_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   rd_en,
  input  logic                   err_d,
  input  logic [7:0]             offset,
  input  logic [2:0]             req_size,
  input  logic [HDR_BYTES*8-1:0] hdr_flat,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_err
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < DATA_W / 8; i++) begin
      logic [8:0] idx;
      idx = {1'b0, offset} + 9'(i);
      if ((3'(i) < req_size) && (idx < 9'(HDR_BYTES)))
        pick[i*8 +: 8] = hdr_flat[idx[5:0]*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_d;
      rsp_rdata <= rd_en ? pick : '0;
    end
  end
endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
  import cfgh_pkg::*;
#(
  parameter int                  NUM_BAR   = 6,
  parameter logic [4:0]          DEV_NUM   = 5'd3,
  parameter logic [2:0]          FUNC_NUM  = 3'd1,
  parameter logic [15:0]         VENDOR_ID = 16'h1A2B,
  parameter logic [15:0]         DEVICE_ID = 16'h3C4D,
  parameter logic [7:0]          REV_ID    = 8'h07,
  parameter logic [23:0]         CLASS_ID  = 24'h020000,
  parameter logic [7:0]          HDR_TYPE  = 8'h80,
  parameter logic [7:0]          INT_PIN   = 8'h01,
  parameter logic [NUM_BAR*32-1:0] BAR_SIZES =
    {32'h20, 32'h0, 32'h0, 32'h10000, 32'h1000, 32'h100},
  parameter logic [NUM_BAR*4-1:0]  BAR_LOWS  =
    {4'h1, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [15:0]        req_addr,
  input  logic [2:0]         req_size,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic [NUM_BAR-1:0] map_add,
  output logic [NUM_BAR-1:0] map_change
);
  logic               hit;
  logic               rd_en;
  logic [7:0]         offset;
  logic               wr_cmd;
  logic               wr_rom;
  logic [NUM_BAR-1:0] bar_wr;
  logic               err_d;
  logic [15:0]        cmd_q;
  logic [31:0]        rom_q;
  logic [31:0]        bar_q [NUM_BAR];
  logic [HDR_BYTES*8-1:0] hdr_flat;

  cfgh_decode #(.NUM_BAR(NUM_BAR), .DEV_NUM(DEV_NUM), .FUNC_NUM(FUNC_NUM)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .hit       (hit),
    .rd_en     (rd_en),
    .offset    (offset),
    .wr_cmd    (wr_cmd),
    .wr_rom    (wr_rom),
    .wr_bar    (bar_wr),
    .err_d     (err_d)
  );

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    cfgh_bar #(.BAR_SZ(BAR_SIZES[i*32 +: 32]), .LOW_INIT(BAR_LOWS[i*4 +: 4])) u_bar (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bar_wr[i]),
      .wdata     (req_wdata),
      .bar_q     (bar_q[i]),
      .add_pulse (map_add[i]),
      .chg_pulse (map_change[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      rom_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= req_wdata[15:0];
      if (wr_rom) rom_q <= rom_next(req_wdata);
    end
  end

  always_comb begin
    hdr_flat = '0;
    hdr_flat[8'h00*8 +: 16] = VENDOR_ID;
    hdr_flat[8'h02*8 +: 16] = DEVICE_ID;
    hdr_flat[OFF_CMD*8 +: 16] = cmd_q;
    hdr_flat[8'h08*8 +: 8]  = REV_ID;
    hdr_flat[8'h09*8 +: 24] = CLASS_ID;
    hdr_flat[8'h0E*8 +: 8]  = HDR_TYPE;
    for (int i = 0; i < NUM_BAR; i++)
      hdr_flat[(int'(OFF_BAR0) + 4*i)*8 +: 32] = bar_q[i];
    hdr_flat[OFF_ROM*8 +: 32] = rom_q;
    hdr_flat[8'h3D*8 +: 8] = INT_PIN;
  end

  cfgh_rdport u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rd_en     (rd_en),
    .err_d     (err_d),
    .offset    (offset),
    .req_size  (req_size),
    .hdr_flat  (hdr_flat),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/cfgh_check.sv
module cfgh_check #(
  parameter int         NUM_BAR  = 6,
  parameter logic [4:0] DEV_NUM  = 5'd3,
  parameter logic [2:0] FUNC_NUM = 3'd1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [15:0]        req_addr,
  input logic [2:0]         req_size,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic               rsp_err,
  input logic [NUM_BAR-1:0] map_add,
  input logic [NUM_BAR-1:0] map_change,
  input logic [NUM_BAR-1:0] bar_wr
);
  logic ours;
  logic bad_sz;
  logic [NUM_BAR-1:0] add_seen;

  assign ours   = (req_addr[15:11] == DEV_NUM) && (req_addr[10:8] == FUNC_NUM);
  assign bad_sz = !((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4));

  always_ff @(posedge clk) begin
    if (!rst_n) add_seen <= '0;
    else        add_seen <= add_seen | map_add;
  end

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r1_foreign_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !ours) |=> (!rsp_err && rsp_rdata == 32'd0));
  a_r1_foreign_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !ours) |=> rsp_err);
  a_r3_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ours && bad_sz) |=> (rsp_err && rsp_rdata == 32'd0));
  a_r5_beyond_header_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && ours && req_size == 3'd1 && req_addr[7:6] != 2'b00)
      |=> (rsp_rdata == 32'd0));
  a_r12_add_chg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (map_add & map_change) == '0);
  a_r12_add_once: assert property (@(posedge clk) disable iff (!rst_n)
    (map_add & add_seen) == '0);
  a_r12_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((map_add | map_change) != '0) |-> (($past(bar_wr) & (map_add | map_change)) != '0));
  a_r11_single_bar_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_wr));
endmodule

bind cfg_hdr_regfile cfgh_check #(.NUM_BAR(NUM_BAR), .DEV_NUM(DEV_NUM), .FUNC_NUM(FUNC_NUM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .map_add    (map_add),
  .map_change (map_change),
  .bar_wr     (bar_wr)
);

// File: tb/cfg_hdr_regfile_test.sv
module cfg_hdr_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [5:0]  map_add;
  logic [5:0]  map_change;

  int total = 0;
  int bad = 0;
  logic [31:0] g_data;
  logic        g_err;
  logic        g_valid;
  logic [5:0]  g_add;
  logic [5:0]  g_chg;

  localparam logic [15:0] BASE  = 16'h1900; // device 3, function 1
  localparam logic [15:0] OTHER_FN  = 16'h1A00; // device 3, function 2
  localparam logic [15:0] OTHER_DEV = 16'h2100; // device 4, function 1

  always #5 clk = ~clk;

  cfg_hdr_regfile uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .map_add(map_add), .map_change(map_change)
  );

  // {offset, size, expected data} for reads right after reset
  localparam int NVEC = 14;
  localparam logic [43:0] RD_VEC [NVEC] = '{
    {8'h00, 4'd4, 32'h3C4D1A2B},
    {8'h02, 4'd2, 32'h00003C4D},
    {8'h01, 4'd1, 32'h0000001A},
    {8'h03, 4'd2, 32'h0000003C},
    {8'h08, 4'd4, 32'h02000007},
    {8'h0E, 4'd1, 32'h00000080},
    {8'h0C, 4'd4, 32'h00800000},
    {8'h3C, 4'd4, 32'h00000100},
    {8'h04, 4'd4, 32'h00000000},
    {8'h10, 4'd4, 32'h00000001},
    {8'h18, 4'd4, 32'h00000008},
    {8'h24, 4'd4, 32'h00000001},
    {8'h3D, 4'd4, 32'h00000001},
    {8'h40, 4'd1, 32'h00000000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] addr, input logic [2:0] sz,
                        input logic [31:0] wd);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_size  = sz;
    req_wdata = wd;
    @(negedge clk);
    g_valid = rsp_valid;
    g_data  = rsp_rdata;
    g_err   = rsp_err;
    g_add   = map_add;
    g_chg   = map_change;
    req_valid = 1'b0;
    req_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] off, input logic [2:0] sz,
                           input logic [31:0] exp);
    access(1'b0, BASE | 16'(off), sz, 32'd0);
    check(tag, g_data, exp);
    check({tag, " err"}, 32'(g_err), 32'd0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: reset state of outputs
    check("R4 rsp_valid idle", 32'(rsp_valid), 32'd0);
    check("R4 map pulses idle", 32'({map_add, map_change}), 32'd0);

    // R2 R4 R5: table of reads after reset
    for (int i = 0; i < NVEC; i++) begin
      access(1'b0, BASE | 16'(RD_VEC[i][43:36]), RD_VEC[i][34:32], 32'd0);
      check($sformatf("R4 R2 R5 vec%0d data", i), g_data, RD_VEC[i][31:0]);
      check($sformatf("R2 vec%0d valid", i), 32'(g_valid), 32'd1);
      check($sformatf("R2 vec%0d err", i), 32'(g_err), 32'd0);
    end

    // R6: sizing probes
    access(1'b1, BASE | 16'h10, 3'd4, 32'hFFFFFFFF);
    check("R6 probe io err", 32'(g_err), 32'd0);
    check("R6 probe no pulse", 32'({g_add, g_chg}), 32'd0);
    rd_expect("R6 io bar size mask", 8'h10, 3'd4, 32'hFFFFFF01);
    access(1'b1, BASE | 16'h14, 3'd4, 32'hFFFFFFFF);
    rd_expect("R6 mem bar size mask", 8'h14, 3'd4, 32'hFFFFF000);
    access(1'b1, BASE | 16'h18, 3'd4, 32'hFFFFFFFF);
    rd_expect("R6 mem bar type kept", 8'h18, 3'd4, 32'hFFFF0008);
    access(1'b1, BASE | 16'h24, 3'd4, 32'hFFFFFFFF);
    rd_expect("R6 small io bar", 8'h24, 3'd4, 32'hFFFFFFE1);

    // R7 R12: ordinary BAR writes
    access(1'b1, BASE | 16'h10, 3'd4, 32'h0000ABCE);
    check("R12 first add pulse", 32'(g_add), 32'h01);
    check("R12 first no change", 32'(g_chg), 32'h00);
    rd_expect("R7 io low2 kept", 8'h10, 3'd4, 32'h0000ABCD);
    access(1'b1, BASE | 16'h10, 3'd4, 32'h00001234);
    check("R12 reassign change", 32'(g_chg), 32'h01);
    check("R12 reassign no add", 32'(g_add), 32'h00);
    rd_expect("R7 io rewrite", 8'h10, 3'd4, 32'h00001235);
    access(1'b1, BASE | 16'h14, 3'd4, 32'h00000000);
    check("R12 zero write no pulse", 32'({g_add, g_chg}), 32'd0);
    rd_expect("R7 mem zero", 8'h14, 3'd4, 32'h00000000);
    access(1'b1, BASE | 16'h18, 3'd4, 32'h80000007);
    check("R12 bar2 add", 32'(g_add), 32'h04);
    rd_expect("R7 mem low4 kept", 8'h18, 3'd4, 32'h80000008);
    access(1'b1, BASE | 16'h14, 3'd4, 32'hC000000F);
    check("R12 bar1 add after zero", 32'(g_add), 32'h02);
    rd_expect("R7 mem low4 zero", 8'h14, 3'd4, 32'hC0000000);

    // R8: zero-size BAR
    access(1'b1, BASE | 16'h1C, 3'd4, 32'hFFFFFFFF);
    check("R8 probe err", 32'(g_err), 32'd0);
    access(1'b1, BASE | 16'h1C, 3'd4, 32'h12345670);
    check("R8 no pulse", 32'({g_add, g_chg}), 32'd0);
    rd_expect("R8 reads zero", 8'h1C, 3'd4, 32'h00000000);

    // R9: ROM base
    access(1'b1, BASE | 16'h30, 3'd4, 32'hFFFFFFFE);
    check("R9 probe err", 32'(g_err), 32'd0);
    rd_expect("R9 probe all ones", 8'h30, 3'd4, 32'hFFFFFFFF);
    access(1'b1, BASE | 16'h30, 3'd4, 32'h12345678);
    rd_expect("R9 store", 8'h30, 3'd4, 32'h12345678);

    // R10: command
    access(1'b1, BASE | 16'h04, 3'd2, 32'h5555BEEF);
    check("R10 cmd err", 32'(g_err), 32'd0);
    rd_expect("R10 cmd read", 8'h04, 3'd4, 32'h0000BEEF);

    // R11: rejected writes
    access(1'b1, BASE | 16'h00, 3'd4, 32'h00000000);
    check("R11 ro write err", 32'(g_err), 32'd1);
    rd_expect("R11 ro unchanged", 8'h00, 3'd4, 32'h3C4D1A2B);
    access(1'b1, BASE | 16'h04, 3'd1, 32'h00000011);
    check("R11 byte cmd err", 32'(g_err), 32'd1);
    access(1'b1, BASE | 16'h12, 3'd4, 32'h00000000);
    check("R11 unaligned bar err", 32'(g_err), 32'd1);
    check("R11 unaligned no pulse", 32'({g_add, g_chg}), 32'd0);
    rd_expect("R11 cmd unchanged", 8'h04, 3'd2, 32'h0000BEEF);
    rd_expect("R11 bar unchanged", 8'h10, 3'd4, 32'h00001235);

    // R1: foreign device / function
    access(1'b1, OTHER_FN | 16'h10, 3'd4, 32'h0000F000);
    check("R1 foreign write err", 32'(g_err), 32'd1);
    check("R1 foreign write no pulse", 32'({g_add, g_chg}), 32'd0);
    rd_expect("R1 bar kept", 8'h10, 3'd4, 32'h00001235);
    access(1'b0, OTHER_DEV | 16'h00, 3'd4, 32'd0);
    check("R1 foreign read data", g_data, 32'd0);
    check("R1 foreign read err", 32'(g_err), 32'd0);
    access(1'b0, OTHER_DEV | 16'h00, 3'd3, 32'd0);
    check("R1 foreign bad size ignored", 32'(g_err), 32'd0);

    // R3: illegal sizes
    access(1'b0, BASE | 16'h00, 3'd3, 32'd0);
    check("R3 read size3 err", 32'(g_err), 32'd1);
    check("R3 read size3 data", g_data, 32'd0);
    access(1'b1, BASE | 16'h30, 3'd0, 32'h0BADF00D);
    check("R3 write size0 err", 32'(g_err), 32'd1);
    rd_expect("R3 rom unchanged", 8'h30, 3'd4, 32'h12345678);

    // R2: no response when idle
    check("R2 idle no rsp", 32'(rsp_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule